// File: doc/BRIEF.md
# I2C EEPROM Target with Page Write Buffer

This block is an I2C target that sits in front of a 256-byte memory held in a register array. A system clock oversamples the bus. The block finds START and STOP conditions and compares the 7-bit device address. It then takes a one-byte word address. After that it either returns bytes from a running read pointer or collects data bytes in a 16-byte page buffer. Buffered bytes reach the array only when a valid STOP ends the write. A timed busy window follows, during which the target does not answer its own address.

The target only pulls SDA low. The output `sda_oe` means "pull the line low", so the pad can be wired with other open-drain drivers. Two level inputs can block programming: a write-protect pin and a supply-good flag. A blocked write is still acknowledged byte by byte, but it changes no stored data and starts no busy window. Analog pad drivers, spike filtering and non-volatile storage are left outside the block.

Top module: `i2c_eeprom_tgt`

## Requirements
- R1: A byte made of the 7-bit device address `DEV_ADDR` (default 0x50) in bits 7..1 and the direction in bit 0 (1 = read, 0 = write) is acknowledged when the address matches and no write cycle is running. A byte with any other address gets no acknowledge, and the target ignores the bus until the next START.
- R2: The byte after a write-direction address byte is the word address. It is acknowledged and loads the read/write pointer. A repeated START with a read-direction address then returns the byte at that pointer (random read).
- R3: A sequential read returns one byte per controller ACK, advancing the pointer across all 8 bits so that 0xFF is followed by 0x00. A controller NACK ends the read.
- R4: Data bytes of a write are acknowledged and buffered. On a valid STOP, one byte or a full 16-byte page is programmed, each byte at the address it was written to.
- R5: While buffering, only the low 4 pointer bits advance, wrapping within the 16-byte page. The 17th and later bytes replace the bytes buffered at those page positions.
- R6: Nothing is stored before the STOP. A START that arrives before the STOP discards the buffered data, so it is never programmed.
- R7: After a programming STOP the target is busy for `WR_TICKS` clock cycles. During that time it does not acknowledge its device address. After that time it acknowledges again.
- R8: When `wp_i` is 1 at the STOP, the data bytes have still been acknowledged, but no byte is stored and no busy window starts.
- R9: When `pwr_ok_i` is 0 at the STOP, the data bytes have still been acknowledged, but no byte is stored and no busy window starts.
- R10: `sda_oe` is asserted only while SCL is low. The target never drives SDA high.
- R11: During and after reset `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| wp_i | input | 1 | Write protect, 1 blocks programming |
| pwr_ok_i | input | 1 | Supply above threshold, 0 blocks programming |

## Verification
The bound checker watches the following on every cycle:
- the pull-down enable starts only while SCL is low;
- a busy window opens only after a commit request made while writes were enabled;
- no buffer write or commit request appears while busy;
- every busy window lasts exactly the programmed tick count.

Stored content can only be shown through bus scenarios run by the bench. These cover the wrap inside a page, the overwrite of earlier buffered bytes, the read rollover at the top of the array, the discard of data when a START arrives before the STOP, and the acknowledged but unstored writes under write protect or low supply.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int unsigned WADDR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADR,
    ST_WDAT,
    ST_ACK,
    ST_RDAT,
    ST_RACK
  } eep_state_e;
endpackage

// File: rtl/eep_bus_edge.sv
module eep_bus_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // one extra stage holds the previous synchronized level
  logic [SYNC_STAGES:0] scl_pipe, sda_pipe;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign scl_q = scl_pipe[SYNC_STAGES];
  assign sda_s = sda_pipe[SYNC_STAGES-1];
  assign sda_q = sda_pipe[SYNC_STAGES];

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int unsigned PAGE_W   = 4,
  parameter int unsigned WR_TICKS = 1000000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          buf_clr,
  input  logic [eep_pkg::WADDR_W-PAGE_W-1:0] buf_base,
  input  logic                          buf_wr,
  input  logic [PAGE_W-1:0]             buf_idx,
  input  logic [7:0]                    buf_data,
  input  logic                          commit_req,
  input  logic                          wr_enable,
  input  logic [eep_pkg::WADDR_W-1:0]   rd_addr,
  output logic [7:0]                    rd_data,
  output logic                          busy
);
  localparam int unsigned DEPTH = 1 << eep_pkg::WADDR_W;
  localparam int unsigned PAGE  = 1 << PAGE_W;
  localparam int unsigned CNT_W = $clog2(WR_TICKS + 1);
  localparam int unsigned BASE_W = eep_pkg::WADDR_W - PAGE_W;

  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PAGE];
  logic [PAGE-1:0]   pvld_q, pvld_n;
  logic [BASE_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              do_commit;

  assign busy      = (cnt_q != '0);
  assign do_commit = commit_req & wr_enable & ~busy;
  assign rd_data   = mem[rd_addr];

  always_comb begin
    pvld_n = pvld_q;
    if (buf_clr || do_commit) pvld_n = '0;
    else if (buf_wr)          pvld_n[buf_idx] = 1'b1;
  end

  always_comb begin
    cnt_n = cnt_q;
    if (do_commit)  cnt_n = CNT_W'(WR_TICKS);
    else if (busy)  cnt_n = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pvld_q <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      pvld_q <= pvld_n;
      cnt_q  <= cnt_n;
      if (buf_clr) base_q <= buf_base;
    end
  end

  // data storage carries no reset
  always_ff @(posedge clk) begin
    if (buf_wr) pbuf[buf_idx] <= buf_data;
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < PAGE; p++) begin
      if (do_commit && pvld_q[p]) mem[{base_q, PAGE_W'(p)}] <= pbuf[p];
    end
  end
endmodule

// File: rtl/eep_proto.sv
module eep_proto
  import eep_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h50,
  parameter int unsigned PAGE_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sda_s,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     start_det,
  input  logic                     stop_det,
  input  logic                     busy,
  input  logic [7:0]               rd_data,
  output logic                     sda_drv,
  output logic [WADDR_W-1:0]       rd_addr,
  output logic                     buf_clr,
  output logic [WADDR_W-PAGE_W-1:0] buf_base,
  output logic                     buf_wr,
  output logic [PAGE_W-1:0]        buf_idx,
  output logic [7:0]               buf_data,
  output logic                     commit_req
);
  eep_state_e         state_q, state_n, after_q, after_n;
  logic [2:0]         bit_q, bit_n;
  logic [7:0]         sh_q, sh_n;
  logic [WADDR_W-1:0] ptr_q, ptr_n;
  logic               drv_q, drv_n, full_q, full_n, sess_q, sess_n;

  assign sda_drv  = drv_q;
  assign rd_addr  = ptr_q;
  assign buf_base = sh_q[WADDR_W-1:PAGE_W];
  assign buf_idx  = ptr_q[PAGE_W-1:0];
  assign buf_data = sh_q;

  always_comb begin
    state_n = state_q; after_n = after_q; bit_n = bit_q; sh_n = sh_q;
    ptr_n = ptr_q; drv_n = drv_q; full_n = full_q; sess_n = sess_q;
    buf_clr = 1'b0; buf_wr = 1'b0; commit_req = 1'b0;
    if (stop_det) begin
      state_n = ST_IDLE; drv_n = 1'b0; full_n = 1'b0;
      commit_req = sess_q; sess_n = 1'b0;
    end else if (start_det) begin
      state_n = ST_DEV; drv_n = 1'b0; bit_n = '0; full_n = 1'b0; sess_n = 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (scl_rise && !full_q) begin
            sh_n  = {sh_q[6:0], sda_s};
            bit_n = bit_q + 3'd1;
            if (bit_q == 3'd7) full_n = 1'b1;
          end else if (scl_fall && full_q) begin
            full_n = 1'b0; bit_n = '0; state_n = ST_ACK; drv_n = 1'b1;
            case (state_q)
              ST_DEV: begin
                if (sh_q[7:1] == DEV_ADDR && !busy) begin
                  after_n = sh_q[0] ? ST_RDAT : ST_WADR;
                end else begin
                  state_n = ST_IDLE; drv_n = 1'b0;
                end
              end
              ST_WADR: begin
                ptr_n = sh_q; buf_clr = 1'b1; after_n = ST_WDAT;
              end
              default: begin
                buf_wr  = 1'b1; sess_n = 1'b1; after_n = ST_WDAT;
                ptr_n   = {ptr_q[WADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            drv_n = 1'b0; state_n = after_q;
            if (after_q == ST_RDAT) begin
              sh_n = rd_data; drv_n = ~rd_data[7]; bit_n = '0;
            end
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (bit_q == 3'd7) begin
              drv_n = 1'b0; state_n = ST_RACK; ptr_n = ptr_q + 8'd1; full_n = 1'b0;
            end else begin
              sh_n = {sh_q[6:0], 1'b0}; bit_n = bit_q + 3'd1; drv_n = ~sh_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            if (sda_s) state_n = ST_IDLE;
            else       full_n  = 1'b1;
          end else if (scl_fall && full_q) begin
            full_n = 1'b0; state_n = ST_RDAT; sh_n = rd_data;
            drv_n = ~rd_data[7]; bit_n = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; after_q <= ST_IDLE; bit_q <= '0; sh_q <= '0;
      ptr_q <= '0; drv_q <= 1'b0; full_q <= 1'b0; sess_q <= 1'b0;
    end else begin
      state_q <= state_n; after_q <= after_n; bit_q <= bit_n; sh_q <= sh_n;
      ptr_q <= ptr_n; drv_q <= drv_n; full_q <= full_n; sess_q <= sess_n;
    end
  end
endmodule

// File: rtl/i2c_eeprom_tgt.sv
module i2c_eeprom_tgt #(
  parameter logic [6:0]  DEV_ADDR    = 7'h50,
  parameter int unsigned PAGE_W      = 4,
  parameter int unsigned WR_TICKS    = 1000000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic wp_i,
  input  logic pwr_ok_i
);
  localparam int unsigned BASE_W = eep_pkg::WADDR_W - PAGE_W;

  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       busy, buf_clr, buf_wr, commit_req, sda_drv;
  logic [BASE_W-1:0]           buf_base;
  logic [PAGE_W-1:0]           buf_idx;
  logic [7:0]                  buf_data, rd_data;
  logic [eep_pkg::WADDR_W-1:0] rd_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  eep_bus_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_proto #(.DEV_ADDR(DEV_ADDR), .PAGE_W(PAGE_W)) u_proto (
    .clk(clk), .rst_n(rst_int_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .busy(busy), .rd_data(rd_data), .sda_drv(sda_drv), .rd_addr(rd_addr),
    .buf_clr(buf_clr), .buf_base(buf_base), .buf_wr(buf_wr),
    .buf_idx(buf_idx), .buf_data(buf_data), .commit_req(commit_req)
  );

  eep_store #(.PAGE_W(PAGE_W), .WR_TICKS(WR_TICKS)) u_store (
    .clk(clk), .rst_n(rst_int_n), .buf_clr(buf_clr), .buf_base(buf_base),
    .buf_wr(buf_wr), .buf_idx(buf_idx), .buf_data(buf_data),
    .commit_req(commit_req), .wr_enable(~wp_i & pwr_ok_i),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  assign sda_oe = sda_drv;
endmodule

// File: rtl/eep_tgt_chk.sv
module eep_tgt_chk #(
  parameter int unsigned WR_TICKS = 1000000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic wp_i,
  input logic pwr_ok_i,
  input logic busy,
  input logic buf_wr,
  input logic commit_req
);
  logic [31:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 32'd1;
    else           busy_len <= '0;
  end

  // R10: pull-down starts only in the SCL low phase
  assert_pull_in_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  // R8 and R9: a busy window needs writes enabled at the commit request
  assert_busy_needs_enable_R8_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(commit_req) && !$past(wp_i) && $past(pwr_ok_i)));

  // R7: no buffer activity while the array is programming
  assert_no_buf_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !buf_wr);

  assert_no_commit_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !commit_req);

  // R7: the busy window lasts exactly WR_TICKS cycles
  assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == 32'(WR_TICKS)));
endmodule

bind i2c_eeprom_tgt eep_tgt_chk #(.WR_TICKS(WR_TICKS)) u_eep_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .wp_i(wp_i),
  .pwr_ok_i(pwr_ok_i), .busy(busy), .buf_wr(buf_wr), .commit_req(commit_req)
);

// File: tb/test_i2c_eeprom_tgt.sv
`timescale 1ns/1ps
module test_i2c_eeprom_tgt;
  localparam int WR = 600;
  localparam int Q  = 8;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mscl = 1'b1, msda = 1'b1, wp = 1'b0, pwr_ok = 1'b1;
  logic sda_oe;
  wire  sda_line = msda & ~sda_oe;

  int n_checks = 0, n_err = 0, r10_bad = 0;
  bit done = 1'b0;
  logic [7:0] model [256];
  logic [7:0] wbuf  [32];
  logic [7:0] exp_q [$];
  logic [7:0] act_q [$];
  string      tag_q [$];
  logic       oe_prev = 1'b0;

  always #2.5 clk = ~clk;

  i2c_eeprom_tgt #(.DEV_ADDR(DEV), .WR_TICKS(WR)) i_i2c_eeprom_tgt (
    .clk(clk), .rst_n(rst_n), .scl_i(mscl), .sda_i(sda_line),
    .sda_oe(sda_oe), .wp_i(wp), .pwr_ok_i(pwr_ok)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    if (!mscl) begin msda = 1'b1; tick(Q); mscl = 1'b1; tick(Q); end
    msda = 1'b0; tick(2*Q); mscl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    msda = 1'b0; tick(Q); mscl = 1'b1; tick(Q); msda = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; tick(Q); mscl = 1'b1; tick(2*Q); mscl = 1'b0; tick(Q);
    end
    msda = 1'b1; tick(Q); mscl = 1'b1; tick(Q); ack = ~sda_line;
    tick(Q); mscl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    b = '0;
    msda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); mscl = 1'b1; tick(Q); b = {b[6:0], sda_line}; tick(Q); mscl = 1'b0;
    end
    tick(Q); msda = ~mack; tick(Q); mscl = 1'b1; tick(2*Q); mscl = 1'b0; tick(Q);
  endtask

  task automatic send_ck(input logic [7:0] b, input logic exp_ack, input string tag);
    logic a;
    send_byte(b, a);
    check(a === exp_ack, tag, int'(a), int'(exp_ack));
  endtask

  // buffered write of n bytes from wbuf; the model follows only when stored
  task automatic page_write(input logic [7:0] wa, input int n, input bit store, input string tag);
    bus_start();
    send_ck({DEV, 1'b0}, 1'b1, {tag, " dev ack"});
    send_ck(wa, 1'b1, {tag, " word addr ack"});
    for (int k = 0; k < n; k++) begin
      send_ck(wbuf[k], 1'b1, {tag, " data ack"});
      if (store) model[{wa[7:4], wa[3:0] + 4'(k)}] = wbuf[k];
    end
    bus_stop();
  endtask

  task automatic seq_read(input logic [7:0] wa, input int n, input string tag);
    logic [7:0] b;
    bus_start();
    send_ck({DEV, 1'b0}, 1'b1, {tag, " dev ack"});
    send_ck(wa, 1'b1, {tag, " word addr ack"});
    bus_start();
    send_ck({DEV, 1'b1}, 1'b1, {tag, " read dev ack"});
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(model[8'(wa + 8'(k))]);
      tag_q.push_back(tag);
      recv_byte(k != n - 1, b);
      act_q.push_back(b);
    end
    bus_stop();
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      logic [7:0] a, e;
      string t;
      wait (act_q.size() != 0);
      a = act_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      check(a === e, {t, " read data"}, int'(a), int'(e));
    end
  end

  // R10 observer: a new pull-down must not begin while SCL is high
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && mscl) r10_bad++;
    oe_prev <= sda_oe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++; n_checks++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    check(sda_oe === 1'b0, "R11 oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    tick(10);
    check(sda_oe === 1'b0, "R11 oe after reset", int'(sda_oe), 0);

    // R1: wrong address, then the following byte is ignored too
    bus_start();
    send_ck({7'h51, 1'b0}, 1'b0, "R1 foreign address nack");
    send_ck(8'h00, 1'b0, "R1 ignored until start");
    bus_stop();

    // R4/R7: single byte write, then the busy window
    wbuf[0] = 8'hA5;
    page_write(8'h23, 1, 1'b1, "R4 byte write");
    bus_start();
    send_ck({DEV, 1'b0}, 1'b0, "R7 nack while busy");
    bus_stop();
    tick(WR);
    bus_start();
    send_ck({DEV, 1'b0}, 1'b1, "R7 ack after busy");
    bus_stop();
    seq_read(8'h23, 1, "R2 random read");

    // R4: full page
    for (int k = 0; k < 16; k++) wbuf[k] = 8'h10 + 8'(k);
    page_write(8'h40, 16, 1'b1, "R4 page write");
    tick(WR + 40);
    seq_read(8'h40, 16, "R4 page readback");

    // R5: 20 bytes starting at 0x5E wrap inside the page
    for (int k = 0; k < 20; k++) wbuf[k] = 8'h80 + 8'(k);
    page_write(8'h5E, 20, 1'b1, "R5 wrap write");
    tick(WR + 40);
    seq_read(8'h50, 16, "R5 wrap readback");

    // R3: read across the top of the array
    wbuf[0] = 8'hE0; wbuf[1] = 8'hE1;
    page_write(8'hFE, 2, 1'b1, "R3 top write");
    tick(WR + 40);
    wbuf[0] = 8'hC0; wbuf[1] = 8'hC1;
    page_write(8'h00, 2, 1'b1, "R3 bottom write");
    tick(WR + 40);
    seq_read(8'hFE, 4, "R3 rollover read");

    // R6: a START before the STOP discards buffered data
    begin
      logic [7:0] b;
      bus_start();
      send_ck({DEV, 1'b0}, 1'b1, "R6 dev ack");
      send_ck(8'h23, 1'b1, "R6 word addr ack");
      send_ck(8'h77, 1'b1, "R6 data ack");
      bus_start();
      send_ck({DEV, 1'b0}, 1'b1, "R6 restart dev ack");
      send_ck(8'h23, 1'b1, "R6 restart word addr");
      bus_start();
      send_ck({DEV, 1'b1}, 1'b1, "R6 read dev ack");
      exp_q.push_back(8'hA5); tag_q.push_back("R6 discarded data");
      recv_byte(1'b0, b);
      act_q.push_back(b);
      bus_stop();
    end

    // R8: write protect blocks storage and the busy window
    wp = 1'b1;
    wbuf[0] = 8'h11;
    page_write(8'h23, 1, 1'b0, "R8 protected write");
    wp = 1'b0;
    seq_read(8'h23, 1, "R8 no busy, data kept");

    // R9: low supply blocks storage and the busy window
    pwr_ok = 1'b0;
    wbuf[0] = 8'h99; wbuf[1] = 8'h98;
    page_write(8'h40, 2, 1'b0, "R9 low supply write");
    pwr_ok = 1'b1;
    seq_read(8'h40, 2, "R9 no busy, data kept");

    tick(50);
    check(act_q.size() == 0 && exp_q.size() == 0, "scoreboard drained",
          act_q.size() + exp_q.size(), 0);
    check(r10_bad == 0, "R10 pull-down only with SCL low", r10_bad, 0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule